// File: doc/BRIEF.md
# CAN Receive Acceptance Decision

This block decides, once per received CAN frame, whether one receive buffer takes the frame. It looks at the frame identifier (11-bit standard or 29-bit extended), the frame's extended flag, a 2-bit receive mode belonging to the buffer, and a bank of identifier/mask filters. Each filter also has an extended-select bit. The block returns an accept flag, a flag and index for the lowest-numbered matching filter, and a flag that marks a frame delivered even though it was cut off by a bus error.

The receiver front end pulses `frameEnd` when a frame finishes cleanly, or `frameErr` when an error cuts it short. It holds the identifier, the extended flag and the configuration steady in that cycle. The registered decision appears on the outputs in the next cycle, together with a one-cycle `decValid` pulse. The buffer logic stores the frame when `accept` is high in that cycle.

Top module: `canRxAccept`

## Requirements
- R1: `decValid` is high exactly in the cycle after a cycle in which `frameEnd` or `frameErr` is high, and low in every other cycle. The other outputs carry the decision made in that strobe cycle.
- R2: A filter matches when the masked identifier bits are equal to the masked filter bits, in every position where the mask bit is 1. For a standard frame only bits [10:0] are compared. For an extended frame all bits [28:0] are compared.
- R3: A filter can match only when its extended-select bit equals the frame's extended flag. `frameExt` = 0 means standard and 1 means extended.
- R4: In mode 2'b00 a clean frame is accepted exactly when at least one filter matches.
- R5: In mode 2'b01 only standard frames can be accepted. Filters whose extended-select bit is 1 never match, and extended frames are rejected.
- R6: In mode 2'b10 only extended frames can be accepted. Filters whose extended-select bit is 0 never match, and standard frames are rejected.
- R7: In mode 2'b11 every clean frame is accepted, whether or not any filter matches. `hitFound` and `hitIdx` still report the filter match found under R2 and R3.
- R8: When several filters match, `hitIdx` is the lowest matching filter number.
- R9: On an error strobe in mode 2'b11, the frame is accepted with `partial` = 1 and `hitFound` = 0. In any other mode an error strobe gives `accept` = 0.
- R10: When `frameEnd` and `frameErr` are high in the same cycle, the frame is treated as an errored frame.
- R11: After reset, and in every cycle where `decValid` is low, `accept`, `partial`, `hitFound` and `hitIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameId | input | 29 | Received identifier; a standard identifier sits in bits [10:0] |
| frameExt | input | 1 | 1 = extended frame, 0 = standard frame |
| frameEnd | input | 1 | Frame completed without error (one-cycle strobe) |
| frameErr | input | 1 | Frame cut off by an error (one-cycle strobe) |
| rxMode | input | 2 | Receive mode: 00 filtered, 01 standard only, 10 extended only, 11 accept all |
| fltId | input | NUM_FLT*29 | Filter identifiers; filter i occupies bits [i*29 +: 29] |
| fltMask | input | NUM_FLT*29 | Filter masks; filter i occupies bits [i*29 +: 29] |
| fltExt | input | NUM_FLT | Extended-select bit of each filter |
| decValid | output | 1 | Decision valid pulse |
| accept | output | 1 | Buffer takes the frame |
| partial | output | 1 | Frame was accepted although it ended in an error |
| hitFound | output | 1 | At least one filter matched |
| hitIdx | output | IDX_W | Lowest matching filter number |

## Verification
The end-of-frame path and the error path can both fire in the same cycle. The bench therefore drives every identifier and mode combination three times: as a clean end, as an error, and with both strobes raised together. It expects the combined case to give exactly the error-path result: acceptance only in mode 11 with `partial` set, and no filter hit. The sweep covers four modes, both frame types, three filter banks and eight identifiers. The expected values are derived arithmetically from the mode and filter rules.

// File: rtl/canRxAcceptPkg.sv
package canRxAcceptPkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef enum logic [1:0] {
    MODE_FILTERED = 2'b00,
    MODE_STD_ONLY = 2'b01,
    MODE_EXT_ONLY = 2'b10,
    MODE_PASS_ALL = 2'b11
  } rxMode_e;

  typedef struct packed {
    logic evalClean;  // clean frame end, no error present
    logic evalTrunc;  // errored frame (error wins over end)
    logic allowStd;   // standard-select filters may match
    logic allowExt;   // extended-select filters may match
    logic passAll;    // accept regardless of filters
  } ctrlStrb_t;
endpackage

// File: rtl/canRxAcceptCtrl.sv
module canRxAcceptCtrl
  import canRxAcceptPkg::*;
(
  input  logic      frameEnd,
  input  logic      frameErr,
  input  logic [1:0] rxMode,
  output ctrlStrb_t strb
);
  rxMode_e modeE;
  assign modeE = rxMode_e'(rxMode);

  always_comb begin
    strb           = '0;
    strb.evalTrunc = frameErr;
    strb.evalClean = frameEnd & ~frameErr;
    unique case (modeE)
      MODE_FILTERED: begin strb.allowStd = 1'b1; strb.allowExt = 1'b1; end
      MODE_STD_ONLY: begin strb.allowStd = 1'b1; end
      MODE_EXT_ONLY: begin strb.allowExt = 1'b1; end
      MODE_PASS_ALL: begin strb.allowStd = 1'b1; strb.allowExt = 1'b1; strb.passAll = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/canRxAcceptPath.sv
module canRxAcceptPath
  import canRxAcceptPkg::*;
#(
  parameter int NUM_FLT = 4,
  parameter int IDX_W   = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [ID_W-1:0]       frameId,
  input  logic                  frameExt,
  input  logic [NUM_FLT*ID_W-1:0] fltId,
  input  logic [NUM_FLT*ID_W-1:0] fltMask,
  input  logic [NUM_FLT-1:0]    fltExt,
  output logic                  decValid,
  output logic                  accept,
  output logic                  partial,
  output logic                  hitFound,
  output logic [IDX_W-1:0]      hitIdx
);
  localparam logic [ID_W-1:0] STD_SPAN = ID_W'((1 << STD_W) - 1);

  logic [NUM_FLT-1:0] fltHit;
  logic [ID_W-1:0]    spanMask;
  assign spanMask = frameExt ? '1 : STD_SPAN;

  for (genvar g = 0; g < NUM_FLT; g++) begin : gFlt
    logic [ID_W-1:0] effMask;
    logic            typeOk;
    logic            modeOk;
    assign effMask  = fltMask[g*ID_W +: ID_W] & spanMask;
    assign typeOk   = (fltExt[g] == frameExt);
    assign modeOk   = fltExt[g] ? strb.allowExt : strb.allowStd;
    assign fltHit[g] = typeOk & modeOk &
                       (((frameId ^ fltId[g*ID_W +: ID_W]) & effMask) == '0);
  end

  logic             anyHit;
  logic [IDX_W-1:0] firstIdx;
  always_comb begin
    anyHit   = 1'b0;
    firstIdx = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (fltHit[i]) begin
        anyHit   = 1'b1;
        firstIdx = IDX_W'(i);
      end
    end
  end

  logic nxtAccept, nxtPartial, nxtHit;
  always_comb begin
    nxtAccept  = 1'b0;
    nxtPartial = 1'b0;
    nxtHit     = 1'b0;
    if (strb.evalTrunc) begin
      nxtAccept  = strb.passAll;
      nxtPartial = strb.passAll;
    end else if (strb.evalClean) begin
      nxtHit    = anyHit;
      nxtAccept = anyHit | strb.passAll;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      accept   <= 1'b0;
      partial  <= 1'b0;
      hitFound <= 1'b0;
      hitIdx   <= '0;
    end else begin
      decValid <= strb.evalClean | strb.evalTrunc;
      accept   <= nxtAccept;
      partial  <= nxtPartial;
      hitFound <= nxtHit;
      hitIdx   <= nxtHit ? firstIdx : '0;
    end
  end

  // hit index always points at a filter that exists
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    hitFound |-> (int'(hitIdx) < NUM_FLT));
  // a partial delivery is always an accepted one
  assert_partial_acc_R9: assert property (@(posedge clk) disable iff (!rstN)
    partial |-> accept && !hitFound);
endmodule

// File: rtl/canRxAccept.sv
module canRxAccept
  import canRxAcceptPkg::*;
#(
  parameter int NUM_FLT = 4,
  parameter int IDX_W   = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [28:0]               frameId,
  input  logic                      frameExt,
  input  logic                      frameEnd,
  input  logic                      frameErr,
  input  logic [1:0]                rxMode,
  input  logic [NUM_FLT*29-1:0]     fltId,
  input  logic [NUM_FLT*29-1:0]     fltMask,
  input  logic [NUM_FLT-1:0]        fltExt,
  output logic                      decValid,
  output logic                      accept,
  output logic                      partial,
  output logic                      hitFound,
  output logic [IDX_W-1:0]          hitIdx
);
  ctrlStrb_t strb;

  canRxAcceptCtrl uCtrl (
    .frameEnd(frameEnd), .frameErr(frameErr), .rxMode(rxMode), .strb(strb)
  );

  canRxAcceptPath #(.NUM_FLT(NUM_FLT), .IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .frameId(frameId), .frameExt(frameExt),
    .fltId(fltId), .fltMask(fltMask), .fltExt(fltExt),
    .decValid(decValid), .accept(accept), .partial(partial),
    .hitFound(hitFound), .hitIdx(hitIdx)
  );

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd || frameErr) |=> decValid);
  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(frameEnd || frameErr) |=> !decValid);
  assert_std_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && rxMode == 2'b01 && frameExt) |=> !accept);
  assert_ext_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && rxMode == 2'b10 && !frameExt) |=> !accept);
  assert_pass_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && rxMode == 2'b11) |=> accept);
  assert_err_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && rxMode != 2'b11) |=> !accept);
  assert_err_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && frameEnd) |=> !hitFound);
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!accept && !partial && !hitFound && hitIdx == '0));
endmodule

// File: tb/tb_canRxAccept.sv
module tb_canRxAccept;
  localparam int NF = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [28:0] frameId = '0;
  logic frameExt = 1'b0, frameEnd = 1'b0, frameErr = 1'b0;
  logic [1:0] rxMode = '0;
  logic [NF*29-1:0] fltId = '0, fltMask = '0;
  logic [NF-1:0] fltExt = '0;
  logic decValid, accept, partial, hitFound;
  logic [IW-1:0] hitIdx;

  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  canRxAccept #(.NUM_FLT(NF)) dut (
    .clk(clk), .rstN(rstN), .frameId(frameId), .frameExt(frameExt),
    .frameEnd(frameEnd), .frameErr(frameErr), .rxMode(rxMode),
    .fltId(fltId), .fltMask(fltMask), .fltExt(fltExt),
    .decValid(decValid), .accept(accept), .partial(partial),
    .hitFound(hitFound), .hitIdx(hitIdx)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0d ext=%0b id=%0h)",
               req, act, exp, rxMode, frameExt, frameId);
    end
  endtask

  // Filter bank configuration s
  task automatic setBank(input int s);
    for (int i = 0; i < NF; i++) begin
      logic [28:0] base;
      base = 29'(32'h0ABC_1230 * (s + 1) + 32'h0101_0357 * i);
      if (s == 2) base = 29'h0155_5555;  // same id everywhere: priority test
      fltId[i*29 +: 29]   = base;
      fltMask[i*29 +: 29] = (s == 0) ? '1 :
                            (s == 1) ? 29'h1FFF_FFF0 :
                                       29'(29'h1FFF_FFFF << (i * 3));
      fltExt[i] = (s == 0) ? i[0] : (s == 1) ? i[1] : (i >= 2);
    end
  endtask

  // Expected decision from the requirements
  task automatic model(input logic trunc, output logic eA, output logic eP,
                       output logic eH, output logic [IW-1:0] eI);
    eA = 0; eP = 0; eH = 0; eI = '0;
    if (trunc) begin  // R9, R10
      eA = (rxMode == 2'b11); eP = eA;
      return;
    end
    for (int i = NF - 1; i >= 0; i--) begin
      logic [28:0] m;
      logic ok;
      m  = fltMask[i*29 +: 29] & (frameExt ? 29'h1FFF_FFFF : 29'h7FF);   // R2
      ok = (fltExt[i] == frameExt);                                         // R3
      if (rxMode == 2'b01 && fltExt[i]) ok = 0;                             // R5
      if (rxMode == 2'b10 && !fltExt[i]) ok = 0;                            // R6
      if (ok && (((frameId ^ fltId[i*29 +: 29]) & m) == 0)) begin
        eH = 1; eI = IW'(i);                                                // R8
      end
    end
    eA = eH | (rxMode == 2'b11);                                            // R4, R7
  endtask

  task automatic runFrame(input int kind);  // 0 clean, 1 error, 2 both
    logic eA, eP, eH;
    logic [IW-1:0] eI;
    @(negedge clk);
    frameEnd = (kind != 1);
    frameErr = (kind != 0);
    model(kind != 0, eA, eP, eH, eI);
    @(negedge clk);
    frameEnd = 0; frameErr = 0;
    chk("R1 decValid", 8'(decValid), 8'd1);
    if (kind == 2) begin
      chk("R10 accept", 8'(accept), 8'(eA));
      chk("R10 partial", 8'(partial), 8'(eP));
    end else if (kind == 1) begin
      chk("R9 accept", 8'(accept), 8'(eA));
      chk("R9 partial", 8'(partial), 8'(eP));
    end else begin
      case (rxMode)
        2'b00: chk("R4 accept", 8'(accept), 8'(eA));
        2'b01: chk("R5 accept", 8'(accept), 8'(eA));
        2'b10: chk("R6 accept", 8'(accept), 8'(eA));
        default: chk("R7 accept", 8'(accept), 8'(eA));
      endcase
      chk("R9 partial clean", 8'(partial), 8'd0);
    end
    chk("R2 R3 hitFound", 8'(hitFound), 8'(eH));
    chk("R8 hitIdx", 8'(hitIdx), 8'(eI));
    @(negedge clk);
    chk("R1 decValid drop", 8'(decValid), 8'd0);
    chk("R11 idle accept", 8'(accept), 8'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R11 reset decValid", 8'(decValid), 8'd0);
    chk("R11 reset accept", 8'(accept), 8'd0);
    chk("R11 reset hitIdx", 8'(hitIdx), 8'd0);
    rstN = 1'b1;
    for (int s = 0; s < 3; s++) begin
      setBank(s);
      for (int md = 0; md < 4; md++) begin
        rxMode = 2'(md);
        for (int e = 0; e < 2; e++) begin
          frameExt = e[0];
          for (int k = 0; k < 8; k++) begin
            if (k < NF)      frameId = fltId[k*29 +: 29];
            else if (k == 4) frameId = fltId[29 +: 29] ^ 29'h0000_0805; // upper-bit diff
            else if (k == 5) frameId = fltId[0 +: 29] ^ 29'h0000_0009; // low nibble diff
            else             frameId = 29'(32'h1357_9BDF * k);
            for (int kind = 0; kind < 3; kind++) runFrame(kind);
          end
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule